// File: doc/BRIEF.md
# Eight-Line Vectored Interrupt Controller

This block collects up to eight interrupt requests from peripherals and presents a single interrupt line to a processor. Each request input is edge-sensitive: a rising edge latches a pending bit. Pending lines are filtered by a per-line mask, and the lowest-numbered unmasked pending line wins. It raises the processor interrupt only if no line of equal or higher priority is already being serviced. When the processor acknowledges, the controller marks the winner as in service, clears its pending bit and hands back an 8-bit vector: a programmable base plus the winning line number.

Software reaches the controller through a two-address register port, with one address for commands and one for data. A command write with bit 4 set starts a configuration sequence. The next data write sets the vector base, and the one after that stores a cascade configuration byte. A final optional data write stores a processor-mode bit. Once configured, data writes load the mask. Command writes can also end an in-service state or choose which status register a command read returns.

Top module: `intc8_top`

## Requirements
- R1: After reset, `int_out` is 0, `vec_out` is 0x00, and the mask, pending and in-service registers all read 0. The controller is unconfigured and the command read selects the pending register.
- R2: A command write with bit 4 set starts configuration and clears the mask, pending and in-service registers. Its bit 0 set means a fourth word follows. The next data write sets the vector base, and the one after it stores the cascade byte on `cfg_cascade`. If a fourth word was announced, the following data write stores its bit 0 on `cfg_mode86`. The last word of the sequence makes the controller configured.
- R3: A rising edge on `irq_in[n]` sets pending bit n, whether or not the line is masked and whether or not the controller is configured. A line held high does not set the bit again.
- R4: While configured, a data write loads the mask (bit n masks line n), and a data read always returns the mask. A masked pending line never raises `int_out` but stays pending.
- R5: Priority is fixed, with line 0 highest. `int_out` is 1 only when some unmasked line is pending and its index is lower than every in-service index.
- R6: An `int_ack` pulse while `int_out` is 1 (and no configuration start is written in the same cycle) sets the winner's in-service bit and clears its pending bit. One cycle later `vec_out` equals (base + line index) mod 256. An `int_ack` while `int_out` is 0 changes nothing.
- R7: Command value 0x20 clears the lowest-numbered in-service bit. Command 0x60 | n (n = 0..7) clears in-service bit n.
- R8: Command 0x0A makes command-address reads return the pending register, and 0x0B makes them return the in-service register.
- R9: Any command write without bit 4 while the controller waits for word 2, 3 or 4 returns it to the unconfigured state. In the unconfigured state, data writes do not change the mask.
- R10: While unconfigured or mid-sequence, `int_out` stays 0 even with unmasked requests pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising edge latched |
| bus_wr | input | 1 | Register write strobe |
| bus_sel_data | input | 1 | Address: 0 = command, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Processor acknowledge pulse |
| vec_out | output | 8 | Vector of the last granted acknowledge |
| cfg_cascade | output | 8 | Stored cascade configuration byte |
| cfg_mode86 | output | 1 | Stored processor-mode bit |

## Verification
On every cycle, the assertions check the following:
- `int_out` appears only when the controller is configured and some pending line is unmasked.
- No equal-or-higher-priority line is in service while `int_out` is asserted.
- A configuration start empties all three registers.
- A granted acknowledge sets the winner's in-service bit and clears its pending bit, and produces base plus index on the vector.
- A non-specific end command drops exactly one in-service bit.

Other behaviour needs the bench's scenarios, because it unfolds over whole sequences. This covers the word counting of the configuration sequence with and without the fourth word, an abort in the middle of it, and the edge-only latching of held requests. It also covers vector wraparound near base 0xFC, nested servicing, and the read-select and mask readback paths.

// File: rtl/intc8_pkg.sv
package intc8_pkg;
  typedef enum logic [2:0] {
    SQ_UNCFG = 3'd0,
    SQ_W2    = 3'd1,
    SQ_W3    = 3'd2,
    SQ_W4    = 3'd3,
    SQ_RDY   = 3'd4
  } seq_state_e;

  localparam int INIT_BIT  = 4;
  localparam int NEED4_BIT = 0;
  localparam int RDSEL_BIT = 3;
  localparam int SEL_BIT   = 0;
  localparam logic [2:0] OPC_EOI_ANY = 3'b001;
  localparam logic [2:0] OPC_EOI_ONE = 3'b011;
endpackage

// File: rtl/intc8_seq.sv
module intc8_seq
  import intc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          init_start,
  output logic          cmd_op,
  output logic          mask_wr,
  output logic          cfg_ready,
  output logic [DW-1:0] base_q,
  output logic [DW-1:0] cascade_q,
  output logic          mode86_q
);
  seq_state_e st_q, st_d;
  logic       need4_q;
  logic       settled;

  assign settled    = (st_q == SQ_UNCFG) || (st_q == SQ_RDY);
  assign init_start = cmd_wr && wdata[INIT_BIT];
  assign cmd_op     = cmd_wr && !init_start && settled;
  assign mask_wr    = data_wr && (st_q == SQ_RDY);
  assign cfg_ready  = (st_q == SQ_RDY);

  always_comb begin
    st_d = st_q;
    if (init_start) begin
      st_d = SQ_W2;
    end else if (cmd_wr && !settled) begin
      st_d = SQ_UNCFG;
    end else if (data_wr) begin
      case (st_q)
        SQ_W2:   st_d = SQ_W3;
        SQ_W3:   st_d = need4_q ? SQ_W4 : SQ_RDY;
        SQ_W4:   st_d = SQ_RDY;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_UNCFG;
      need4_q   <= 1'b0;
      base_q    <= '0;
      cascade_q <= '0;
      mode86_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (init_start) need4_q <= wdata[NEED4_BIT];
      if (data_wr && st_q == SQ_W2) base_q    <= wdata;
      if (data_wr && st_q == SQ_W3) cascade_q <= wdata;
      if (data_wr && st_q == SQ_W4) mode86_q  <= wdata[0];
    end
  end
endmodule

// File: rtl/intc8_prio.sv
module intc8_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  input  logic [N-1:0]  isr,
  output logic [IW-1:0] win_idx,
  output logic [IW-1:0] isr_idx,
  output logic          isr_any,
  output logic          win_beats
);
  function automatic logic [IW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  logic cand_any;

  assign cand_any  = |cand;
  assign isr_any   = |isr;
  assign win_idx   = lowest_set(cand);
  assign isr_idx   = lowest_set(isr);
  assign win_beats = cand_any && (!isr_any || (win_idx < isr_idx));
endmodule

// File: rtl/intc8_regs.sv
module intc8_regs #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          init_start,
  input  logic          ack_grant,
  input  logic [IW-1:0] win_idx,
  input  logic [N-1:0]  isr_clr,
  input  logic          mask_wr,
  input  logic [DW-1:0] wdata,
  output logic [N-1:0]  req_q,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  mask_q
);
  logic [N-1:0] irq_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_prev_q <= '0;
      mask_q     <= '0;
    end else begin
      irq_prev_q <= irq_in;
      if (init_start)   mask_q <= '0;
      else if (mask_wr) mask_q <= wdata[N-1:0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic hit;
    logic rise;
    logic pend_q;
    logic serv_q;

    assign hit  = ack_grant && (win_idx == IW'(g));
    assign rise = irq_in[g] && !irq_prev_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n || init_start) begin
        pend_q <= 1'b0;
        serv_q <= 1'b0;
      end else begin
        if (hit)       pend_q <= 1'b0;
        else if (rise) pend_q <= 1'b1;
        if (hit)             serv_q <= 1'b1;
        else if (isr_clr[g]) serv_q <= 1'b0;
      end
    end

    assign req_q[g] = pend_q;
    assign isr_q[g] = serv_q;
  end
endmodule

// File: rtl/intc8_top.sv
module intc8_top
  import intc8_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic                 bus_sel_data,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 int_out,
  input  logic                 int_ack,
  output logic [DATA_W-1:0]    vec_out,
  output logic [DATA_W-1:0]    cfg_cascade,
  output logic                 cfg_mode86
);
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  function automatic logic [DATA_W-1:0] vec_of(input logic [DATA_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    return b + DATA_W'(i);
  endfunction

  logic                 cmd_wr, data_wr;
  logic                 init_start, cmd_op, mask_wr, cfg_ready;
  logic [DATA_W-1:0]    base_q;
  logic [NUM_LINES-1:0] req_q, isr_q, mask_q, isr_clr;
  logic [IDX_W-1:0]     win_idx, isr_idx;
  logic                 isr_any, win_beats, ack_grant;
  logic [2:0]           opc;
  logic                 rdsel_q;
  logic [DATA_W-1:0]    vec_q;

  assign cmd_wr  = bus_wr && !bus_sel_data;
  assign data_wr = bus_wr && bus_sel_data;
  assign opc     = bus_wdata[DATA_W-1 -: 3];

  intc8_seq #(.DW(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .wdata(bus_wdata), .init_start(init_start), .cmd_op(cmd_op),
    .mask_wr(mask_wr), .cfg_ready(cfg_ready), .base_q(base_q),
    .cascade_q(cfg_cascade), .mode86_q(cfg_mode86)
  );

  intc8_prio #(.N(NUM_LINES), .IW(IDX_W)) u_prio (
    .cand(req_q & ~mask_q), .isr(isr_q), .win_idx(win_idx),
    .isr_idx(isr_idx), .isr_any(isr_any), .win_beats(win_beats)
  );

  assign int_out   = cfg_ready && win_beats;
  assign ack_grant = int_ack && int_out && !init_start;

  always_comb begin
    isr_clr = '0;
    if (cmd_op) begin
      if (opc == OPC_EOI_ANY && isr_any) isr_clr[isr_idx] = 1'b1;
      else if (opc == OPC_EOI_ONE)       isr_clr[bus_wdata[IDX_W-1:0]] = 1'b1;
    end
  end

  intc8_regs #(.N(NUM_LINES), .IW(IDX_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .init_start(init_start),
    .ack_grant(ack_grant), .win_idx(win_idx), .isr_clr(isr_clr),
    .mask_wr(mask_wr), .wdata(bus_wdata), .req_q(req_q), .isr_q(isr_q),
    .mask_q(mask_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdsel_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      if (cmd_op && bus_wdata[RDSEL_BIT]) rdsel_q <= bus_wdata[SEL_BIT];
      if (ack_grant) vec_q <= vec_of(base_q, win_idx);
    end
  end

  assign vec_out   = vec_q;
  assign bus_rdata = bus_sel_data ? DATA_W'(mask_q)
                   : (rdsel_q ? DATA_W'(isr_q) : DATA_W'(req_q));
endmodule

// File: rtl/intc8_chk.sv
module intc8_chk #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_out,
  input logic [DW-1:0] vec_out,
  input logic          cfg_ready,
  input logic          init_start,
  input logic          ack_grant,
  input logic          cmd_op,
  input logic [2:0]    eoi_opc,
  input logic [IW-1:0] win_idx,
  input logic [N-1:0]  req_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  mask_q,
  input logic [DW-1:0] base_q
);
  function automatic logic [N-1:0] upto(input logic [IW-1:0] k);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i <= int'(k));
    return m;
  endfunction

  p_int_needs_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> cfg_ready);

  p_int_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((req_q & ~mask_q) != '0));

  p_prio_nesting_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((isr_q & upto(win_idx)) == '0));

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (req_q == '0 && isr_q == '0 && mask_q == '0));

  p_ack_sets_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_grant |=> (isr_q[$past(win_idx)] && !req_q[$past(win_idx)]));

  p_ack_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_grant |=> (vec_out == $past(base_q) + DW'($past(win_idx))));

  p_eoi_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op && eoi_opc == 3'b001 && !ack_grant && isr_q != '0)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind intc8_top intc8_chk #(.N(NUM_LINES), .IW(IDX_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .vec_out(vec_out),
  .cfg_ready(cfg_ready), .init_start(init_start), .ack_grant(ack_grant),
  .cmd_op(cmd_op), .eoi_opc(opc), .win_idx(win_idx), .req_q(req_q),
  .isr_q(isr_q), .mask_q(mask_q), .base_q(base_q)
);

// File: tb/tb_intc8_top.sv
`timescale 1ns/1ps
module tb_intc8_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       bus_wr = 1'b0;
  logic       bus_sel_data = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_out;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;
  logic [7:0] cfg_cascade;
  logic       cfg_mode86;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intc8_top dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_out(int_out), .int_ack(int_ack), .vec_out(vec_out),
    .cfg_cascade(cfg_cascade), .cfg_mode86(cfg_mode86)
  );

  // Bench model: 0 unconfigured, 1..3 waiting for word 2..4, 4 configured
  int         m_st;
  bit         m_need4, m_sel, m_mode;
  logic [7:0] m_mask, m_req, m_isr, m_base, m_prev, m_vec, m_casc;

  function automatic int f_low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit f_int();
    logic [7:0] c;
    c = m_req & ~m_mask;
    return (m_st == 4) && (c != 0) && (f_low(c) < f_low(m_isr));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_need4 = 0; m_sel = 0; m_mode = 0;
    m_mask = 0; m_req = 0; m_isr = 0; m_base = 0; m_prev = 0; m_vec = 0; m_casc = 0;
  endtask

  task automatic model_step(input logic [7:0] irq, input bit ack, input bit wr,
                            input bit to_data, input logic [7:0] wd);
    bit init, cmd_op, grant;
    int win, top;
    logic [7:0] rise, clr;
    init   = wr && !to_data && wd[4];
    cmd_op = wr && !to_data && !init && (m_st == 0 || m_st == 4);
    grant  = ack && f_int() && !init;
    win    = f_low(m_req & ~m_mask);
    top    = f_low(m_isr);
    rise   = irq & ~m_prev;
    m_prev = irq;
    if (init) begin
      m_mask = 0; m_req = 0; m_isr = 0; m_st = 1; m_need4 = wd[0];
    end else begin
      m_req = m_req | rise;
      if (grant) m_req[win] = 1'b0;
      clr = 0;
      if (cmd_op && wd[7:5] == 3'b001 && top < 8) clr[top] = 1'b1;
      if (cmd_op && wd[7:5] == 3'b011) clr[wd[2:0]] = 1'b1;
      m_isr = m_isr & ~clr;
      if (grant) begin
        m_isr[win] = 1'b1;
        m_vec = m_base + 8'(win);
      end
      if (cmd_op && wd[3]) m_sel = wd[0];
      if (wr && !to_data && m_st >= 1 && m_st <= 3) m_st = 0;
      else if (wr && to_data) begin
        case (m_st)
          1: begin m_base = wd; m_st = 2; end
          2: begin m_casc = wd; m_st = m_need4 ? 3 : 4; end
          3: begin m_mode = wd[0]; m_st = 4; end
          4: m_mask = wd;
          default: ;
        endcase
      end
    end
  endtask

  // One clock step: inputs applied at negedge, results compared at the next negedge
  task automatic step(input logic [7:0] irq, input bit ack, input bit wr,
                      input bit to_data, input logic [7:0] wd, input bit rd_data);
    logic [7:0] exp_rd;
    irq_in = irq; int_ack = ack; bus_wr = wr; bus_wdata = wd;
    bus_sel_data = wr ? to_data : rd_data;
    model_step(irq, ack, wr, to_data, wd);
    @(posedge clk);
    #1;
    int_ack = 1'b0; bus_wr = 1'b0; bus_sel_data = rd_data;
    @(negedge clk);
    exp_rd = rd_data ? m_mask : (m_sel ? m_isr : m_req);
    chk("R5 int_out", int'(int_out), int'(f_int()));
    chk("R6 vec_out", int'(vec_out), int'(m_vec));
    chk(rd_data ? "R4 mask readback" : "R8 status readback", int'(bus_rdata), int'(exp_rd));
    chk("R2 cascade", int'(cfg_cascade), int'(m_casc));
    chk("R2 mode", int'(cfg_mode86), int'(m_mode));
  endtask

  task automatic configure(input logic [7:0] base, input bit four,
                           input logic [7:0] casc, input bit mode);
    step(8'h00, 0, 1, 0, 8'h10 | 8'(four), 0);
    step(8'h00, 0, 1, 1, base, 0);
    step(8'h00, 0, 1, 1, casc, 0);
    if (four) step(8'h00, 0, 1, 1, {7'd0, mode}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 int_out", int'(int_out), 0);
    chk("R1 vec_out", int'(vec_out), 0);
    chk("R1 pending read", int'(bus_rdata), 0);
    bus_sel_data = 1'b1; #1;
    chk("R1 mask read", int'(bus_rdata), 0);
    bus_sel_data = 1'b0;

    // R10 / R3: request latched but no interrupt while unconfigured
    step(8'h04, 0, 0, 0, 8'h00, 0);
    chk("R10 no int unconfigured", int'(int_out), 0);
    chk("R3 latch unconfigured", int'(bus_rdata), 8'h04);
    step(8'h04, 0, 0, 0, 8'h00, 0);
    // R9: data write ignored while unconfigured
    step(8'h00, 0, 1, 1, 8'hFF, 1);
    chk("R9 mask unchanged", int'(bus_rdata), 0);

    // R2: four-word sequence, base 32
    configure(8'h20, 1, 8'h04, 1);
    chk("R2 cascade stored", int'(cfg_cascade), 8'h04);
    chk("R2 mode stored", int'(cfg_mode86), 1);
    chk("R2 pending cleared", int'(bus_rdata), 0);

    // R5 / R6: lines 0 and 1 together, base 32
    step(8'h03, 0, 0, 0, 8'h00, 0);
    chk("R5 int raised", int'(int_out), 1);
    step(8'h00, 1, 0, 0, 8'h00, 0);
    chk("R6 vector line0", int'(vec_out), 32);
    chk("R5 blocked by line0 in service", int'(int_out), 0);
    step(8'h00, 0, 1, 0, 8'h0B, 0);
    chk("R8 in-service read", int'(bus_rdata), 8'h01);
    step(8'h00, 0, 1, 0, 8'h20, 0);
    chk("R7 nonspecific end", int'(bus_rdata), 0);
    step(8'h00, 1, 0, 0, 8'h00, 0);
    chk("R6 vector line1", int'(vec_out), 33);
    // R6: acknowledge while idle changes nothing
    step(8'h00, 0, 1, 0, 8'h61, 0);
    step(8'h00, 1, 0, 0, 8'h00, 0);
    chk("R6 idle ack keeps vector", int'(vec_out), 33);
    chk("R6 idle ack no service", int'(bus_rdata), 0);

    // R3: held line does not retrigger
    step(8'h08, 0, 0, 0, 8'h00, 0);
    step(8'h08, 1, 0, 0, 8'h00, 0);
    step(8'h08, 0, 1, 0, 8'h63, 0);
    chk("R3 held line no retrigger", int'(int_out), 0);

    // R4: masked line stays pending
    step(8'h00, 0, 1, 1, 8'h10, 1);
    step(8'h10, 0, 0, 0, 8'h00, 1);
    chk("R4 masked no int", int'(int_out), 0);
    chk("R4 mask read", int'(bus_rdata), 8'h10);

    // R9: abort mid-sequence
    step(8'h00, 0, 1, 0, 8'h10, 0);
    step(8'h00, 0, 1, 0, 8'h0A, 0);
    step(8'h01, 0, 0, 0, 8'h00, 0);
    chk("R9 aborted no int", int'(int_out), 0);

    // R6 wraparound: base 0xFC, line 5
    configure(8'hFC, 0, 8'h00, 0);
    step(8'h20, 0, 0, 0, 8'h00, 0);
    step(8'h00, 1, 0, 0, 8'h00, 0);
    chk("R6 vector wrap", int'(vec_out), 8'h01);

    // Random phase with the bench model
    configure(8'h40, 0, 8'h02, 0);
    for (int n = 0; n < 1500; n++) begin
      int r;
      bit rd;
      r  = int'($urandom % 10);
      rd = bit'($urandom % 2);
      if (n % 300 == 299) begin
        configure(8'($urandom), bit'($urandom % 2), 8'($urandom), bit'($urandom % 2));
      end else begin
        case (r)
          0, 1, 2: step(8'($urandom & $urandom), 0, 0, 0, 8'h00, rd);
          3, 4:    step(8'h00, 1, 0, 0, 8'h00, rd);
          5:       step(8'h00, 0, 1, 0, 8'h20, rd);
          6:       step(8'h00, 0, 1, 0, 8'h60 | 8'($urandom % 8), rd);
          7:       step(8'h00, 0, 1, 1, 8'($urandom & $urandom & $urandom), rd);
          8:       step(8'h00, 0, 1, 0, 8'h0A | 8'($urandom % 2), rd);
          default: step(8'h00, 0, 0, 0, 8'h00, rd);
        endcase
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule